// File: doc/BRIEF.md
# Odd-Square Sequence Chain

This block is a small flow-controlled producer built from a stepping source and a sequential multiplier. The source holds a count and offers it downstream, marking it valid only when the count is odd and not above a configured limit (31 by default). Each time the downstream stage signals that it can take a value, the source advances by one. Even counts are offered as invalid and are still stepped past. Once the count moves beyond the limit it stops and stays there, so no valid value appears again until reset.

The count drives both operands of a shift-and-add multiplier, which therefore squares it. The multiplier asks for input only when it is idle. It works one operand bit per cycle and holds its result until the consumer takes it. A full run emits 1, 9, 25, … 961 in order, then goes quiet for good.

Top module: `oddsq_chain`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `src_value` is 0, `src_valid` is 0, `prod_valid` is 0 and `src_taken` is 1.
- R2: On a rising edge where `src_taken` is 1 and `src_value` is at most LAST_VAL, `src_value` increases by exactly one. On any other edge it holds its value.
- R3: `src_valid` is 1 exactly when `src_value` is odd (bit 0 set) and at most LAST_VAL. It changes only on edges where `src_taken` is 1.
- R4: Once `src_value` exceeds LAST_VAL, it stays at LAST_VAL+1 and never wraps back, so `src_valid` stays 0 until reset.
- R5: `src_taken` is 1 exactly while the multiplier is idle, and it is never 1 while `prod_valid` is 1. A value taken while `src_valid` is 0 is dropped and starts no product.
- R6: `prod_valid` rises exactly DATA_W clock edges after the edge that takes a valid value, and `product` then equals that value squared.
- R7: While `prod_valid` is 1 and `prod_request` is 0, `prod_valid` stays 1 and `product` stays unchanged.
- R8: On an edge where `prod_valid` and `prod_request` are both 1, the product is consumed. In the next cycle `prod_valid` is 0 and `src_taken` is 1.
- R9: Between resets exactly (LAST_VAL+1)/2 products are consumed, equal in order to 1, 9, 25, … (LAST_VAL)², and no valid product appears afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prod_request | input | 1 | Consumer can take the held product this cycle |
| prod_valid | output | 1 | A product is held and valid |
| product | output | 2*DATA_W | Square of a taken odd value |
| src_value | output | CNT_W | Current count of the source |
| src_valid | output | 1 | Current count is an odd value within the limit |
| src_taken | output | 1 | Multiplier idle; count is consumed and stepped on this edge |

## Verification
The assertions check the per-cycle rules on every cycle. These are the source stepping by one or holding, the valid rule on the count, the stop without wraparound, the mutual exclusion of `src_taken` and `prod_valid`, product hold under stall, and release after consumption. A checker counter also caps the number of consumed products. The exact DATA_W-cycle latency, the correctness of each square and the full ordered list of sixteen results need the bench's reference model. That model runs under three consumer patterns (always ready, irregular, long stalls) and across a mid-run reset.

// File: rtl/oddsq_pkg.sv
package oddsq_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_BUSY = 2'd1,
    MS_FULL = 2'd2
  } mul_state_t;

  // Number of odd values from 1 up to and including last
  function automatic int odd_count(input int last);
    return (last + 1) / 2;
  endfunction

endpackage

// File: rtl/odd_seq_src.sv
module odd_seq_src
  import oddsq_pkg::*;
#(
  parameter int LAST_VAL = 31,
  parameter int CNT_W    = $clog2(LAST_VAL + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic [CNT_W-1:0] value,
  output logic             valid
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LAST_VAL);

  logic [CNT_W-1:0] value_q;
  logic             valid_q;
  logic [CNT_W-1:0] value_nxt;
  logic             valid_nxt;

  // Saturate one past the limit so the count can never re-enter the range
  always_comb begin
    value_nxt = (value_q <= LIMIT) ? value_q + 1'b1 : value_q;
    valid_nxt = value_nxt[0] && (value_nxt <= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      value_q <= value_nxt;
      valid_q <= valid_nxt;
    end
  end

  assign value = value_q;
  assign valid = valid_q;

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import oddsq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           in_valid,
  output logic           in_request,
  input  logic           out_request,
  output logic           out_valid,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;
  localparam int SW = (W > 1) ? $clog2(W) : 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(W - 1);

  mul_state_t     state_q;
  logic [PW-1:0]  acc_q;
  logic [PW-1:0]  mcand_q;
  logic [W-1:0]   mplier_q;
  logic [SW-1:0]  step_q;
  logic [PW-1:0]  prod_q;
  logic [PW-1:0]  addend;
  logic [PW-1:0]  sum;

  always_comb begin
    addend = mplier_q[0] ? mcand_q : '0;
    sum    = acc_q + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= MS_IDLE;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      step_q   <= '0;
      prod_q   <= '0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (in_valid) begin
            acc_q    <= '0;
            mcand_q  <= PW'(op_a);
            mplier_q <= op_b;
            step_q   <= '0;
            state_q  <= MS_BUSY;
          end
        end
        MS_BUSY: begin
          acc_q    <= sum;
          mcand_q  <= mcand_q << 1;
          mplier_q <= mplier_q >> 1;
          step_q   <= step_q + 1'b1;
          if (step_q == LAST_STEP) begin
            prod_q  <= sum;
            state_q <= MS_FULL;
          end
        end
        MS_FULL: begin
          if (out_request) state_q <= MS_IDLE;
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign in_request = (state_q == MS_IDLE);
  assign out_valid  = (state_q == MS_FULL);
  assign product    = prod_q;

endmodule

// File: rtl/oddsq_chain.sv
module oddsq_chain
  import oddsq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LAST_VAL = 31,
  parameter int CNT_W    = $clog2(LAST_VAL + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prod_request,
  output logic                prod_valid,
  output logic [2*DATA_W-1:0] product,
  output logic [CNT_W-1:0]    src_value,
  output logic                src_valid,
  output logic                src_taken
);

  logic [DATA_W-1:0] operand;
  logic              mul_in_req;

  odd_seq_src #(
    .LAST_VAL (LAST_VAL),
    .CNT_W    (CNT_W)
  ) u_src (
    .clk   (clk),
    .rst   (rst),
    .take  (mul_in_req),
    .value (src_value),
    .valid (src_valid)
  );

  assign operand = DATA_W'(src_value);

  shift_add_mult #(
    .W (DATA_W)
  ) u_mul (
    .clk         (clk),
    .rst         (rst),
    .op_a        (operand),
    .op_b        (operand),
    .in_valid    (src_valid),
    .in_request  (mul_in_req),
    .out_request (prod_request),
    .out_valid   (prod_valid),
    .product     (product)
  );

  assign src_taken = mul_in_req;

endmodule

// File: rtl/oddsq_chain_chk.sv
module oddsq_chain_chk
  import oddsq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LAST_VAL = 31,
  parameter int CNT_W    = $clog2(LAST_VAL + 2)
) (
  input logic                clk,
  input logic                rst,
  input logic                prod_request,
  input logic                prod_valid,
  input logic [2*DATA_W-1:0] product,
  input logic [CNT_W-1:0]    src_value,
  input logic                src_valid,
  input logic                src_taken
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LAST_VAL);
  localparam int N_OUT = odd_count(LAST_VAL);

  int taken_cnt;
  always_ff @(posedge clk) begin
    if (rst) taken_cnt <= 0;
    else if (prod_valid && prod_request) taken_cnt <= taken_cnt + 1;
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !src_taken |=> $stable(src_value));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (src_taken && src_value <= LIMIT) |=> src_value == $past(src_value) + 1'b1);

  // R3
  valid_rule_chk: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> (src_value[0] && src_value <= LIMIT));

  // R3
  valid_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !src_taken |=> $stable(src_valid));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (src_value > LIMIT) |=> (src_value == $past(src_value) && !src_valid));

  // R5
  taken_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(src_taken && prod_valid));

  // R6
  odd_square_chk: assert property (@(posedge clk) disable iff (rst)
    prod_valid |-> product[0]);

  // R7
  hold_prod_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && !prod_request) |=> (prod_valid && $stable(product)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && prod_request) |=> (!prod_valid && src_taken));

  // R9
  out_bound_chk: assert property (@(posedge clk) disable iff (rst)
    taken_cnt <= N_OUT);

endmodule

bind oddsq_chain oddsq_chain_chk #(
  .DATA_W   (DATA_W),
  .LAST_VAL (LAST_VAL),
  .CNT_W    (CNT_W)
) u_oddsq_chain_chk (
  .clk          (clk),
  .rst          (rst),
  .prod_request (prod_request),
  .prod_valid   (prod_valid),
  .product      (product),
  .src_value    (src_value),
  .src_valid    (src_valid),
  .src_taken    (src_taken)
);

// File: tb/oddsq_chain_bench.sv
`timescale 1ns/1ps
module oddsq_chain_bench;

  localparam int DATA_W   = 8;
  localparam int LAST_VAL = 31;
  localparam int CNT_W    = $clog2(LAST_VAL + 2);
  localparam int N_OUT    = (LAST_VAL + 1) / 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                prod_request = 1'b0;
  logic                prod_valid;
  logic [2*DATA_W-1:0] product;
  logic [CNT_W-1:0]    src_value;
  logic                src_valid;
  logic                src_taken;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oddsq_chain #(.DATA_W(DATA_W), .LAST_VAL(LAST_VAL)) u_oddsq_chain (
    .clk(clk), .rst(rst), .prod_request(prod_request),
    .prod_valid(prod_valid), .product(product),
    .src_value(src_value), .src_valid(src_valid), .src_taken(src_taken)
  );

  // reference model state: 0 idle, 1 busy, 2 full
  int m_cnt, m_state, m_steps, m_opnd, m_prod, m_out;
  bit m_valid;
  logic [15:0] lfsr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_valid = 0; m_state = 0; m_steps = 0;
    m_opnd = 0; m_prod = 0; m_out = 0;
  endtask

  task automatic compare(input string tag);
    check(int'(src_value) == m_cnt, {tag, " R2 src_value"}, int'(src_value), m_cnt);
    check(src_valid == m_valid, {tag, " R3 src_valid"}, int'(src_valid), int'(m_valid));
    check(src_taken == (m_state == 0), {tag, " R5 src_taken"}, int'(src_taken), int'(m_state == 0));
    check(prod_valid == (m_state == 2), {tag, " R6 prod_valid"}, int'(prod_valid), int'(m_state == 2));
    if (m_state == 2)
      check(int'(product) == m_prod, {tag, " R6 product"}, int'(product), m_prod);
  endtask

  // advance the model across the next rising edge, given the request just driven
  task automatic model_step(input bit req);
    int nc;
    case (m_state)
      0: begin
        if (m_valid) begin m_state = 1; m_opnd = m_cnt; m_steps = 0; end
        nc = (m_cnt <= LAST_VAL) ? m_cnt + 1 : m_cnt;
        m_cnt = nc;
        m_valid = (nc % 2 == 1) && (nc <= LAST_VAL);
      end
      1: begin
        m_steps++;
        if (m_steps == DATA_W) begin m_state = 2; m_prod = m_opnd * m_opnd; end
      end
      default: begin
        if (req) begin
          // R9: consumed product must follow the odd-square order
          check(int'(product) == (2*m_out+1)*(2*m_out+1), "R9 order",
                int'(product), (2*m_out+1)*(2*m_out+1));
          m_out++;
          m_state = 0;
        end
      end
    endcase
  endtask

  function automatic bit pick_req(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return lfsr[0] ^ lfsr[3];
      default: return (cyc % 13) == 0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    prod_request = 1'b0;
    @(negedge clk);
    // R1: state during reset
    check(src_value == '0 && !src_valid && !prod_valid && src_taken, "R1 in reset",
          int'(src_value), 0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic run_scenario(input int mode, input int max_cyc, input string tag);
    for (int cyc = 0; cyc < max_cyc; cyc++) begin
      compare(tag);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      prod_request = pick_req(mode, cyc);
      model_step(prod_request);
      @(negedge clk);
    end
  endtask

  initial begin
    lfsr = 16'hACE1;
    model_reset();
    do_reset();
    // R1: first cycle after reset release
    check(src_value == '0 && !src_valid && !prod_valid && src_taken, "R1 after reset",
          int'(src_value), 0);

    run_scenario(0, 500, "always");
    // R4: count parked past the limit, source quiet
    check(int'(src_value) == LAST_VAL + 1, "R4 parked", int'(src_value), LAST_VAL + 1);
    check(!src_valid && !prod_valid, "R4 quiet", int'(src_valid), 0);
    // R9
    check(m_out == N_OUT, "R9 count always", m_out, N_OUT);

    // mid-run reset during irregular consumption
    do_reset();
    run_scenario(1, 60, "irreg-part");
    do_reset();
    check(src_value == '0 && src_taken, "R1 mid-run reset", int'(src_value), 0);
    run_scenario(1, 900, "irreg");
    check(m_out == N_OUT, "R9 count irregular", m_out, N_OUT);

    do_reset();
    run_scenario(2, 2500, "stall");
    check(m_out == N_OUT, "R9 count stall", m_out, N_OUT);
    check(!prod_valid && int'(src_value) == LAST_VAL + 1, "R4 stall end",
          int'(prod_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule